// File: doc/BRIEF.md
# Rounding-Up Unsigned Averager

This block takes two unsigned operands and returns their arithmetic mean as an unsigned value of the same width. When the exact mean falls on a half, the result is rounded toward the larger value. The adder is built without arithmetic or shift operators. A chain of gate-level full-adder cells produces a sum one bit wider than the operands. The lowest carry-in is tied high so that halves round up. The result is the upper bits of that wide sum, so the halving is done by wiring alone and the top carry is kept rather than lost.

The block is purely combinational, with no clock and no state. A parameter chooses between a plain ripple chain and a carry-select chain built from ripple blocks. Both variants give identical results. The default configuration is 8-bit operands with the ripple chain.

Top module: `rnd_up_mean`

## Requirements
- R1: For every operand pair, `mean` equals (opa + opb + 1) / 2 using integer division, computed without wrap-around.
- R2: A mean whose exact value ends in one half is rounded up: operands 12 and 11 give 12.
- R3: A whole-number mean is returned unchanged: operands 12 and 10 give 11.
- R4: A sum of 256 or more does not wrap: operands 127 and 129 give 128.
- R5: Operands 255 and 255 give 255.
- R6: Operands 0 and 0 give 0.
- R7: The result lies between the smaller and the larger operand, inclusive, and equal operands return that operand.
- R8: The output depends only on the present inputs and settles within half a clock period of an input change, with no clock edge involved.
- R9: The ripple variant (ADDER_KIND = ADDER_RIPPLE) and the carry-select variant (ADDER_KIND = ADDER_CSEL, block width CSEL_BLK) give the same output for every input pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH (8) | First unsigned operand |
| opb | input | WIDTH (8) | Second unsigned operand |
| mean | output | WIDTH (8) | Mean of the operands, rounded up on halves |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the operands and `mean`. The bench applies each operand pair just after a rising clock edge and samples half a period later, on the falling edge. The sampled value therefore always belongs to the pair that was just applied. For the settling check, the inputs change in the middle of a cycle and the output is read a nanosecond later, before any clock edge arrives. Every pair is compared against both adder variants at once.

// File: rtl/avg_pkg.sv
package avg_pkg;
   typedef enum logic [0:0] {
      ADDER_RIPPLE = 1'b0,
      ADDER_CSEL   = 1'b1
   } adder_kind_e;
endpackage

// File: rtl/avg_fa_cell.sv
module avg_fa_cell (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   logic p;
   assign p  = a ^ b;
   assign s  = p ^ ci;
   assign co = (a & b) | (ci & p);

   // weight of outputs must equal number of ones on inputs (R1)
   always_comb begin
      assert_fa_count_R1: assert ($countones({a, b, ci}) == int'({co, s}))
         else $error("full-adder cell weight mismatch");
   end
endmodule

// File: rtl/avg_ripple_chain.sv
module avg_ripple_chain #(
   parameter int N = 8
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         ci,
   output logic [N-1:0] s,
   output logic         co
);
   logic [N:0] c;
   assign c[0] = ci;

   for (genvar k = 0; k < N; k++) begin : g_cell
      avg_fa_cell u_fa (
         .a (a[k]),
         .b (b[k]),
         .ci(c[k]),
         .s (s[k]),
         .co(c[k+1])
      );
   end

   assign co = c[N];
endmodule

// File: rtl/avg_csel_chain.sv
module avg_csel_chain #(
   parameter int N   = 8,
   parameter int BLK = 4
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         ci,
   output logic [N-1:0] s,
   output logic         co
);
   localparam int NBLK = N / BLK;

   if ((N % BLK) != 0 || BLK < 1) begin : g_bad_blk
      $error("avg_csel_chain: N must be a multiple of BLK");
   end

   logic [NBLK:0] bc;
   assign bc[0] = ci;

   for (genvar g = 0; g < NBLK; g++) begin : g_blk
      if (g == 0) begin : g_first
         avg_ripple_chain #(.N(BLK)) u_rc (
            .a (a[BLK-1:0]),
            .b (b[BLK-1:0]),
            .ci(bc[0]),
            .s (s[BLK-1:0]),
            .co(bc[1])
         );
      end else begin : g_sel
         logic [BLK-1:0] s0, s1;
         logic           c0, c1;
         avg_ripple_chain #(.N(BLK)) u_rc0 (
            .a (a[g*BLK +: BLK]),
            .b (b[g*BLK +: BLK]),
            .ci(1'b0),
            .s (s0),
            .co(c0)
         );
         avg_ripple_chain #(.N(BLK)) u_rc1 (
            .a (a[g*BLK +: BLK]),
            .b (b[g*BLK +: BLK]),
            .ci(1'b1),
            .s (s1),
            .co(c1)
         );
         assign s[g*BLK +: BLK] = bc[g] ? s1 : s0;
         assign bc[g+1]         = bc[g] ? c1 : c0;

         // a carry-in of one can never yield a smaller carry than zero (R9)
         always_comb begin
            assert_csel_mono_R9: assert (!(c0 && !c1))
               else $error("carry-select block carries inconsistent");
         end
      end
   end

   assign co = bc[NBLK];
endmodule

// File: rtl/rnd_up_mean.sv
module rnd_up_mean
   import avg_pkg::*;
#(
   parameter int          WIDTH      = 8,
   parameter adder_kind_e ADDER_KIND = ADDER_RIPPLE,
   parameter int          CSEL_BLK   = 4
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] mean
);
   localparam int SUM_W = WIDTH + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("rnd_up_mean: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] low_sum;
   logic             top_carry;
   logic [SUM_W-1:0] full_sum;

   if (ADDER_KIND == ADDER_CSEL) begin : g_csel
      avg_csel_chain #(.N(WIDTH), .BLK(CSEL_BLK)) u_add (
         .a (opa),
         .b (opb),
         .ci(1'b1),
         .s (low_sum),
         .co(top_carry)
      );
   end else begin : g_ripple
      avg_ripple_chain #(.N(WIDTH)) u_add (
         .a (opa),
         .b (opb),
         .ci(1'b1),
         .s (low_sum),
         .co(top_carry)
      );
   end

   assign full_sum = {top_carry, low_sum};
   assign mean     = full_sum[SUM_W-1:1];

   always_comb begin
      assert_mean_bounds_R7: assert (
         ((opa <= opb) && (mean >= opa) && (mean <= opb)) ||
         ((opa >  opb) && (mean >= opb) && (mean <= opa)))
         else $error("mean outside operand range");
      assert_equal_ops_R7: assert ((opa != opb) || (mean == opa))
         else $error("equal operands not returned");
      assert_no_overflow_R4: assert (!(opa[WIDTH-1] && opb[WIDTH-1]) || mean[WIDTH-1])
         else $error("top carry lost");
   end
endmodule

// File: tb/rnd_up_mean_tb.sv
module rnd_up_mean_tb;
   import avg_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opa, opb;
   logic [7:0] mean_r, mean_c;
   int         checks = 0;
   int         fails  = 0;
   int         cycles = 0;
   bit         done   = 1'b0;

   always #10 clk = ~clk;

   rnd_up_mean #(.WIDTH(8), .ADDER_KIND(ADDER_RIPPLE)) u_dut (
      .opa(opa), .opb(opb), .mean(mean_r));
   rnd_up_mean #(.WIDTH(8), .ADDER_KIND(ADDER_CSEL), .CSEL_BLK(4)) u_dut_csel (
      .opa(opa), .opb(opb), .mean(mean_c));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: a=%0d b=%0d actual %0d expected %0d", req, opa, opb, act, exp);
      end
   endtask

   task automatic apply(input int a, input int b);
      @(posedge clk);
      opa = 8'(a);
      opb = 8'(b);
      @(negedge clk);
   endtask

   initial begin
      opa = '0;
      opb = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset state", int'(mean_r), 0);

      apply(12, 11);  chk("R2", int'(mean_r), 12);
      apply(11, 12);  chk("R2", int'(mean_c), 12);
      apply(12, 10);  chk("R3", int'(mean_r), 11);
      apply(127, 129); chk("R4", int'(mean_r), 128);
      apply(129, 127); chk("R4", int'(mean_c), 128);
      apply(255, 255); chk("R5", int'(mean_r), 255);
      chk("R5", int'(mean_c), 255);
      apply(0, 0);    chk("R6", int'(mean_r), 0);
      apply(0, 255);  chk("R2", int'(mean_r), 128);
      apply(77, 77);  chk("R7", int'(mean_r), 77);

      // R8: change inputs mid-cycle, read before any edge
      @(posedge clk);
      #5;
      opa = 8'd200;
      opb = 8'd101;
      #1;
      chk("R8", int'(mean_r), 151);
      chk("R8", int'(mean_c), 151);

      // R1 / R9 exhaustive sweep over every pair
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            apply(i, j);
            chk("R1", int'(mean_r), (i + j + 1) / 2);
            chk("R9", int'(mean_c), int'(mean_r));
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule